// File: doc/BRIEF.md
# Integer Execute ALU with Overflow Trap

This block is the integer execute stage of a 32-bit load/store RISC pipeline. It takes the instruction's primary opcode and function field, the two register operand values, the raw 16-bit immediate field and the 5-bit shift amount. In the same cycle it returns the computed result, a flag for signed overflow and a flag for an undefined encoding. It also returns a write-enable qualifier, which tells the writeback stage whether the result may be committed.

A small decoder turns the opcode and function pair into a bundle of strobes. These strobes pick the operation, choose between the second register operand and the extended immediate, choose how the immediate is extended, and enable the overflow trap. One adder serves both the trapping and the non-trapping add and subtract, and it also serves the set-less-than compares. Only the trap enable tells these variants apart. The block has no state and no clock.

Top module: `int_exec_alu`

## Requirements
- R1: With opcode 0x00, function 0x20 (add), 0x21 (addu), 0x22 (sub) and 0x23 (subu) return rs+rt or rs-rt modulo 2^32. Opcodes 0x08 (addi) and 0x09 (addiu) return rs plus the extended immediate.
- R2: add, sub and addi raise `overflowTrap` when the exact signed result falls outside the 32-bit two's-complement range. The wrapped result is still driven, and `writeValid` is low.
- R3: addu, subu, addiu and every operation other than add, sub and addi keep `overflowTrap` low for all operands.
- R4: Function 0x24 gives rs AND rt, 0x25 gives rs OR rt and 0x27 gives NOT(rs OR rt). Opcodes 0x0C (andi) and 0x0D (ori) apply AND and OR to rs and the immediate zero-extended to 32 bits.
- R5: Opcodes 0x08, 0x09, 0x0A (slti) and 0x0B (sltiu) copy immediate bit 15 into bits 31..16 of the second operand.
- R6: Function 0x2A (slt) and opcode 0x0A compare as signed numbers. Function 0x2B (sltu) and opcode 0x0B compare as unsigned numbers, after the same sign extension. The result is exactly 1 when rs is less and 0 otherwise.
- R7: Functions 0x00 (sll), 0x02 (srl) and 0x03 (sra) shift the rt operand by `shamt`. srl fills with zeros and sra fills with copies of bit 31. rs has no effect on them.
- R8: Opcode 0x0F (lui) returns the immediate in bits 31..16 and zeros in bits 15..0.
- R9: Any other opcode, and any other function code under opcode 0, raises `reservedInstr`, returns zero, keeps `overflowTrap` low and keeps `writeValid` low.
- R10: Every defined operation that does not overflow has `writeValid` high and `reservedInstr` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opcode | input | 6 | Primary opcode field |
| funct | input | 6 | Function field, decoded when opcode is 0 |
| rsVal | input | 32 | First register operand |
| rtVal | input | 32 | Second register operand, also the shift source |
| imm16 | input | 16 | Raw immediate field |
| shamt | input | 5 | Shift amount |
| result | output | 32 | Computed result |
| overflowTrap | output | 1 | Signed overflow on a trapping add or subtract |
| reservedInstr | output | 1 | Undefined opcode or function encoding |
| writeValid | output | 1 | Result may be written back |

## Verification
Every output is purely combinational, so each result and flag is due zero cycles after its inputs change. The bench drives a new vector on the falling clock edge. It then waits one time unit before it samples the result, both flags and `writeValid` together, and no stimulus is pending at that moment. Expected values come from 64-bit signed and unsigned arithmetic on the same operands, and every defined operation is swept over a set of corner operands. All 64 function codes and all 64 opcodes are swept for the reserved flag.

// File: rtl/alu_pkg.sv
package alu_pkg;

  localparam int DATA_W = 32;
  localparam int IMM_W = 16;
  localparam int SHAMT_W = $clog2(DATA_W);
  localparam int FIELD_W = 6;

  // primary opcodes
  localparam logic [FIELD_W-1:0] OPC_REG   = 6'h00;
  localparam logic [FIELD_W-1:0] OPC_ADDI  = 6'h08;
  localparam logic [FIELD_W-1:0] OPC_ADDIU = 6'h09;
  localparam logic [FIELD_W-1:0] OPC_SLTI  = 6'h0A;
  localparam logic [FIELD_W-1:0] OPC_SLTIU = 6'h0B;
  localparam logic [FIELD_W-1:0] OPC_ANDI  = 6'h0C;
  localparam logic [FIELD_W-1:0] OPC_ORI   = 6'h0D;
  localparam logic [FIELD_W-1:0] OPC_LUI   = 6'h0F;

  // function codes under OPC_REG
  localparam logic [FIELD_W-1:0] FN_SLL  = 6'h00;
  localparam logic [FIELD_W-1:0] FN_SRL  = 6'h02;
  localparam logic [FIELD_W-1:0] FN_SRA  = 6'h03;
  localparam logic [FIELD_W-1:0] FN_ADD  = 6'h20;
  localparam logic [FIELD_W-1:0] FN_ADDU = 6'h21;
  localparam logic [FIELD_W-1:0] FN_SUB  = 6'h22;
  localparam logic [FIELD_W-1:0] FN_SUBU = 6'h23;
  localparam logic [FIELD_W-1:0] FN_AND  = 6'h24;
  localparam logic [FIELD_W-1:0] FN_OR   = 6'h25;
  localparam logic [FIELD_W-1:0] FN_NOR  = 6'h27;
  localparam logic [FIELD_W-1:0] FN_SLT  = 6'h2A;
  localparam logic [FIELD_W-1:0] FN_SLTU = 6'h2B;

  typedef enum logic [3:0] {
    OP_NONE,
    OP_ADD,
    OP_SUB,
    OP_AND,
    OP_OR,
    OP_NOR,
    OP_SLT,
    OP_SLTU,
    OP_SLL,
    OP_SRL,
    OP_SRA,
    OP_LUI
  } aluOp_e;

  typedef struct packed {
    aluOp_e op;
    logic   useImm;
    logic   zeroExt;
    logic   trapEn;
    logic   reserved;
  } aluCtrl_t;

endpackage

// File: rtl/alu_decode.sv
module alu_decode
  import alu_pkg::*;
(
  input  logic [FIELD_W-1:0] opcode,
  input  logic [FIELD_W-1:0] funct,
  output aluCtrl_t           ctrl
);

  aluCtrl_t regCtrl;
  aluCtrl_t immCtrl;

  // function-field decode for register-register forms
  always_comb begin
    regCtrl = '{op: OP_NONE, useImm: 1'b0, zeroExt: 1'b0, trapEn: 1'b0, reserved: 1'b0};
    case (funct)
      FN_ADD:  begin regCtrl.op = OP_ADD; regCtrl.trapEn = 1'b1; end
      FN_ADDU: regCtrl.op = OP_ADD;
      FN_SUB:  begin regCtrl.op = OP_SUB; regCtrl.trapEn = 1'b1; end
      FN_SUBU: regCtrl.op = OP_SUB;
      FN_AND:  regCtrl.op = OP_AND;
      FN_OR:   regCtrl.op = OP_OR;
      FN_NOR:  regCtrl.op = OP_NOR;
      FN_SLT:  regCtrl.op = OP_SLT;
      FN_SLTU: regCtrl.op = OP_SLTU;
      FN_SLL:  regCtrl.op = OP_SLL;
      FN_SRL:  regCtrl.op = OP_SRL;
      FN_SRA:  regCtrl.op = OP_SRA;
      default: regCtrl.reserved = 1'b1;
    endcase
  end

  // opcode decode for immediate forms, including extension mode
  always_comb begin
    immCtrl = '{op: OP_NONE, useImm: 1'b1, zeroExt: 1'b0, trapEn: 1'b0, reserved: 1'b0};
    case (opcode)
      OPC_ADDI:  begin immCtrl.op = OP_ADD; immCtrl.trapEn = 1'b1; end
      OPC_ADDIU: immCtrl.op = OP_ADD;
      OPC_SLTI:  immCtrl.op = OP_SLT;
      OPC_SLTIU: immCtrl.op = OP_SLTU;
      OPC_ANDI:  begin immCtrl.op = OP_AND; immCtrl.zeroExt = 1'b1; end
      OPC_ORI:   begin immCtrl.op = OP_OR;  immCtrl.zeroExt = 1'b1; end
      OPC_LUI:   immCtrl.op = OP_LUI;
      default: begin
        immCtrl.useImm   = 1'b0;
        immCtrl.reserved = 1'b1;
      end
    endcase
  end

  always_comb begin
    ctrl = (opcode == OPC_REG) ? regCtrl : immCtrl;
  end

  always_comb begin
    if (ctrl.trapEn) begin
      AST_TRAP_ADDSUB_ONLY: assert (ctrl.op == OP_ADD || ctrl.op == OP_SUB)
        else $error("trap enabled on non add/sub op"); // R2
    end
    if (ctrl.zeroExt) begin
      AST_ZEXT_LOGIC_ONLY: assert (ctrl.op == OP_AND || ctrl.op == OP_OR)
        else $error("zero extension on non-logic op"); // R5
    end
    if (ctrl.reserved) begin
      AST_RESERVED_NO_OP: assert (ctrl.op == OP_NONE && !ctrl.trapEn)
        else $error("reserved encoding selects an op"); // R9
    end
  end

endmodule

// File: rtl/alu_shifter.sv
module alu_shifter #(
  parameter int DATA_W  = 32,
  parameter int SHAMT_W = $clog2(DATA_W)
) (
  input  logic [DATA_W-1:0]  value,
  input  logic [SHAMT_W-1:0] amount,
  input  logic               shiftLeft,
  input  logic               shiftArith,
  output logic [DATA_W-1:0]  shifted
);

  logic [DATA_W-1:0] stage [0:SHAMT_W];
  logic [DATA_W-1:0] reversedIn;
  logic [DATA_W-1:0] reversedOut;
  logic              fillBit;

  // left shifts run through the right shifter on a bit-reversed word
  always_comb begin
    for (int b = 0; b < DATA_W; b++) begin
      reversedIn[b] = value[DATA_W-1-b];
    end
  end

  assign fillBit  = shiftArith & ~shiftLeft & value[DATA_W-1];
  assign stage[0] = shiftLeft ? reversedIn : value;

  for (genvar s = 0; s < SHAMT_W; s++) begin : g_stage
    localparam int STEP = 1 << s;
    assign stage[s+1] = amount[s]
                      ? {{STEP{fillBit}}, stage[s][DATA_W-1:STEP]}
                      : stage[s];
  end

  always_comb begin
    for (int b = 0; b < DATA_W; b++) begin
      reversedOut[b] = stage[SHAMT_W][DATA_W-1-b];
    end
  end

  assign shifted = shiftLeft ? reversedOut : stage[SHAMT_W];

  always_comb begin
    if (!shiftLeft && !shiftArith && amount != '0) begin
      AST_SRL_ZERO_TOP: assert (shifted[DATA_W-1] == 1'b0)
        else $error("logical right shift filled a one"); // R7
    end
    if (shiftLeft && amount != '0) begin
      AST_SLL_ZERO_BOTTOM: assert (shifted[0] == 1'b0)
        else $error("left shift filled a one"); // R7
    end
  end

endmodule

// File: rtl/alu_datapath.sv
module alu_datapath
  import alu_pkg::*;
(
  input  aluCtrl_t            ctrl,
  input  logic [DATA_W-1:0]   rsVal,
  input  logic [DATA_W-1:0]   rtVal,
  input  logic [IMM_W-1:0]    imm16,
  input  logic [SHAMT_W-1:0]  shamt,
  output logic [DATA_W-1:0]   result,
  output logic                overflow
);

  localparam int EXT_W = DATA_W - IMM_W;
  localparam int MSB   = DATA_W - 1;

  logic [DATA_W-1:0] immExt;
  logic [DATA_W-1:0] opB;
  logic              isSub;
  logic [DATA_W-1:0] bEff;
  logic [DATA_W:0]   sumWide;
  logic [DATA_W-1:0] sum;
  logic              carryOut;
  logic              signedOvf;
  logic              signedLt;
  logic              unsignedLt;
  logic [DATA_W-1:0] shiftOut;

  // immediate extension, mode chosen by the decoder
  assign immExt = ctrl.zeroExt ? {{EXT_W{1'b0}}, imm16}
                               : {{EXT_W{imm16[IMM_W-1]}}, imm16};
  assign opB    = ctrl.useImm ? immExt : rtVal;

  // one adder for add, subtract and both compares
  assign isSub    = (ctrl.op == OP_SUB) || (ctrl.op == OP_SLT) || (ctrl.op == OP_SLTU);
  assign bEff     = isSub ? ~opB : opB;
  assign sumWide  = {1'b0, rsVal} + {1'b0, bEff} + {{DATA_W{1'b0}}, isSub};
  assign sum      = sumWide[DATA_W-1:0];
  assign carryOut = sumWide[DATA_W];

  assign signedOvf  = (rsVal[MSB] == bEff[MSB]) && (sum[MSB] != rsVal[MSB]);
  assign signedLt   = (rsVal[MSB] != opB[MSB]) ? rsVal[MSB] : sum[MSB];
  assign unsignedLt = ~carryOut;
  assign overflow   = ctrl.trapEn && signedOvf;

  alu_shifter #(
    .DATA_W (DATA_W),
    .SHAMT_W(SHAMT_W)
  ) i_shifter (
    .value     (rtVal),
    .amount    (shamt),
    .shiftLeft (ctrl.op == OP_SLL),
    .shiftArith(ctrl.op == OP_SRA),
    .shifted   (shiftOut)
  );

  always_comb begin
    case (ctrl.op)
      OP_ADD, OP_SUB: result = sum;
      OP_AND:         result = rsVal & opB;
      OP_OR:          result = rsVal | opB;
      OP_NOR:         result = ~(rsVal | opB);
      OP_SLT:         result = {{(DATA_W-1){1'b0}}, signedLt};
      OP_SLTU:        result = {{(DATA_W-1){1'b0}}, unsignedLt};
      OP_SLL, OP_SRL, OP_SRA: result = shiftOut;
      OP_LUI:         result = {imm16, {EXT_W{1'b0}}};
      default:        result = '0;
    endcase
  end

  always_comb begin
    if (ctrl.op == OP_SLT || ctrl.op == OP_SLTU) begin
      AST_SLT_BOOLEAN: assert (result[DATA_W-1:1] == '0)
        else $error("compare result not 0 or 1"); // R6
    end
    if (ctrl.op == OP_LUI) begin
      AST_LUI_LOW_ZERO: assert (result[IMM_W-1:0] == '0)
        else $error("lui low half not zero"); // R8
    end
  end

endmodule

// File: rtl/int_exec_alu.sv
module int_exec_alu
  import alu_pkg::*;
(
  input  logic [5:0]  opcode,
  input  logic [5:0]  funct,
  input  logic [31:0] rsVal,
  input  logic [31:0] rtVal,
  input  logic [15:0] imm16,
  input  logic [4:0]  shamt,
  output logic [31:0] result,
  output logic        overflowTrap,
  output logic        reservedInstr,
  output logic        writeValid
);

  aluCtrl_t ctrl;

  alu_decode i_decode (
    .opcode(opcode),
    .funct (funct),
    .ctrl  (ctrl)
  );

  alu_datapath i_datapath (
    .ctrl    (ctrl),
    .rsVal   (rsVal),
    .rtVal   (rtVal),
    .imm16   (imm16),
    .shamt   (shamt),
    .result  (result),
    .overflow(overflowTrap)
  );

  assign reservedInstr = ctrl.reserved;
  assign writeValid    = !overflowTrap && !ctrl.reserved;

  always_comb begin
    if (reservedInstr) begin
      AST_RESERVED_QUIET: assert (result == '0 && !overflowTrap)
        else $error("reserved encoding drove a result"); // R9
    end
    if (overflowTrap) begin
      AST_NO_OVERFLOW: assert ((opcode == OPC_REG && (funct == FN_ADD || funct == FN_SUB))
                               || opcode == OPC_ADDI)
        else $error("overflow on non-trapping encoding"); // R3
    end
  end

endmodule

// File: tb/test_int_exec_alu.sv
module test_int_exec_alu;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic [5:0]  opcode = '0;
  logic [5:0]  funct = '0;
  logic [31:0] rsVal = '0;
  logic [31:0] rtVal = '0;
  logic [15:0] imm16 = '0;
  logic [4:0]  shamt = '0;
  logic [31:0] result;
  logic        overflowTrap;
  logic        reservedInstr;
  logic        writeValid;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  int_exec_alu i_int_exec_alu (
    .opcode(opcode), .funct(funct), .rsVal(rsVal), .rtVal(rtVal),
    .imm16(imm16), .shamt(shamt), .result(result),
    .overflowTrap(overflowTrap), .reservedInstr(reservedInstr),
    .writeValid(writeValid)
  );

  logic [31:0] vals [8] = '{32'h0, 32'h1, 32'h7fffffff, 32'h80000000,
                            32'hffffffff, 32'hfffffffe, 32'h12345678, 32'ha5a5a5a5};
  logic [15:0] imms [6] = '{16'h0, 16'h1, 16'h7fff, 16'h8000, 16'hffff, 16'h1234};
  logic [5:0]  regFns [12] = '{6'h20, 6'h21, 6'h22, 6'h23, 6'h24, 6'h25,
                               6'h27, 6'h2a, 6'h2b, 6'h00, 6'h02, 6'h03};
  logic [5:0]  immOps [7] = '{6'h08, 6'h09, 6'h0a, 6'h0b, 6'h0c, 6'h0d, 6'h0f};

  function automatic string tagFor(logic [5:0] op, logic [5:0] fn);
    if (op == 6'h00) begin
      case (fn)
        6'h20, 6'h22: return "R2";
        6'h21, 6'h23: return "R3";
        6'h24, 6'h25, 6'h27: return "R4";
        6'h2a, 6'h2b: return "R6";
        6'h00, 6'h02, 6'h03: return "R7";
        default: return "R9";
      endcase
    end
    case (op)
      6'h08: return "R2";
      6'h09: return "R5";
      6'h0a, 6'h0b: return "R6";
      6'h0c, 6'h0d: return "R4";
      6'h0f: return "R8";
      default: return "R9";
    endcase
  endfunction

  // reference model written from the requirements
  task automatic model(input logic [5:0] op, input logic [5:0] fn,
                       input logic [31:0] a, input logic [31:0] b,
                       input logic [15:0] im, input logic [4:0] sh,
                       output logic [34:0] packed_exp);
    logic [31:0] res = '0;
    logic ovf = 1'b0;
    logic rsv = 1'b0;
    logic [31:0] sext = {{16{im[15]}}, im};
    logic [31:0] zext = {16'h0, im};
    longint sa = longint'($signed(a));
    longint sb = longint'($signed(b));
    longint si = longint'($signed(sext));
    longint exact;
    if (op == 6'h00) begin
      case (fn)
        6'h20, 6'h21: begin exact = sa + sb; res = a + b;
                        ovf = (fn == 6'h20) && (exact > 64'sd2147483647 || exact < -64'sd2147483648); end
        6'h22, 6'h23: begin exact = sa - sb; res = a - b;
                        ovf = (fn == 6'h22) && (exact > 64'sd2147483647 || exact < -64'sd2147483648); end
        6'h24: res = a & b;
        6'h25: res = a | b;
        6'h27: res = ~(a | b);
        6'h2a: res = (sa < sb) ? 32'd1 : 32'd0;
        6'h2b: res = (a < b) ? 32'd1 : 32'd0;
        6'h00: res = b << sh;
        6'h02: res = b >> sh;
        6'h03: res = $unsigned($signed(b) >>> sh);
        default: rsv = 1'b1;
      endcase
    end else begin
      case (op)
        6'h08, 6'h09: begin exact = sa + si; res = a + sext;
                        ovf = (op == 6'h08) && (exact > 64'sd2147483647 || exact < -64'sd2147483648); end
        6'h0a: res = (sa < si) ? 32'd1 : 32'd0;
        6'h0b: res = (a < sext) ? 32'd1 : 32'd0;
        6'h0c: res = a & zext;
        6'h0d: res = a | zext;
        6'h0f: res = {im, 16'h0};
        default: rsv = 1'b1;
      endcase
    end
    if (rsv) res = '0;
    packed_exp = {rsv, !(ovf || rsv), ovf, res};
  endtask

  task automatic apply(input logic [5:0] op, input logic [5:0] fn,
                       input logic [31:0] a, input logic [31:0] b,
                       input logic [15:0] im, input logic [4:0] sh,
                       input string tag);
    logic [34:0] expv;
    logic [34:0] got;
    @(negedge clk);
    opcode = op; funct = fn; rsVal = a; rtVal = b; imm16 = im; shamt = sh;
    #1;
    model(op, fn, a, b, im, sh, expv);
    got = {reservedInstr, writeValid, overflowTrap, result};
    total++;
    if (got !== expv) begin
      bad++;
      $display("FAIL %s op=%h fn=%h rs=%h rt=%h imm=%h sh=%0d actual rsv/wv/ovf/res=%b%b%b/%h expected=%b%b%b/%h",
               tag, op, fn, a, b, im, sh, got[34], got[33], got[32], got[31:0],
               expv[34], expv[33], expv[32], expv[31:0]);
    end
  endtask

  initial begin
    // R10: idle all-zero inputs decode to sll by 0 of zero
    apply(6'h00, 6'h00, 32'h0, 32'h0, 16'h0, 5'd0, "R10");
    // R1: directed wraparound without trap
    apply(6'h00, 6'h21, 32'hffffffff, 32'h2, 16'h0, 5'd0, "R1");
    apply(6'h00, 6'h23, 32'h0, 32'h1, 16'h0, 5'd0, "R1");
    // R2: signed overflow both directions
    apply(6'h00, 6'h20, 32'h7fffffff, 32'h1, 16'h0, 5'd0, "R2");
    apply(6'h00, 6'h22, 32'h80000000, 32'h1, 16'h0, 5'd0, "R2");
    apply(6'h08, 6'h00, 32'h7fffffff, 32'h0, 16'h0001, 5'd0, "R2");
    // R3: same operands through non-trapping forms
    apply(6'h00, 6'h21, 32'h7fffffff, 32'h1, 16'h0, 5'd0, "R3");
    apply(6'h09, 6'h00, 32'h7fffffff, 32'h0, 16'h0001, 5'd0, "R3");
    // R6: sltiu sign-extends 0xffff before unsigned compare
    apply(6'h0b, 6'h00, 32'h5, 32'h0, 16'hffff, 5'd0, "R6");
    // R5: addiu with negative immediate
    apply(6'h09, 6'h00, 32'h10, 32'h0, 16'hfff0, 5'd0, "R5");
    // R4: andi zero-extends
    apply(6'h0c, 6'h00, 32'hffffffff, 32'h0, 16'h8001, 5'd0, "R4");

    // register forms over corner operands, shift amount varied
    for (int f = 0; f < 12; f++)
      for (int i = 0; i < 8; i++)
        for (int j = 0; j < 8; j++)
          apply(6'h00, regFns[f], vals[i], vals[j], 16'h0, 5'((i * 5 + j * 3) % 32),
                tagFor(6'h00, regFns[f]));

    // immediate forms; rt carries noise that must not matter
    for (int o = 0; o < 7; o++)
      for (int i = 0; i < 8; i++)
        for (int k = 0; k < 6; k++)
          apply(immOps[o], 6'h3f, vals[i], vals[7 - i], imms[k], 5'd7,
                tagFor(immOps[o], 6'h00));

    // R7: every shift amount, rs noise ignored
    for (int s = 0; s < 32; s++)
      for (int i = 2; i < 8; i++) begin
        apply(6'h00, 6'h00, 32'hdeadbeef, vals[i], 16'h0, 5'(s), "R7");
        apply(6'h00, 6'h02, 32'hdeadbeef, vals[i], 16'h0, 5'(s), "R7");
        apply(6'h00, 6'h03, 32'hdeadbeef, vals[i], 16'h0, 5'(s), "R7");
      end

    // R9: every function code and every opcode, operands that would overflow
    for (int f = 0; f < 64; f++)
      apply(6'h00, 6'(f), 32'h7fffffff, 32'h7fffffff, 16'h7fff, 5'd3, tagFor(6'h00, 6'(f)));
    for (int o = 1; o < 64; o++)
      apply(6'(o), 6'h20, 32'h7fffffff, 32'h7fffffff, 16'h7fff, 5'd3, tagFor(6'(o), 6'h20));

    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule